// File: doc/BRIEF.md
# DMA channel transfer sequencer

This block is the control core of a multi-channel DMA engine. Each channel takes a configuration of source address, destination address, unit count, unit size, address step modes, request source, bus-holding mode and two interrupt enables. The configuration is latched on the rising edge of the channel's enable. Before every transfer unit, the sequencer checks that the channel may run. It then picks among the channels that are requesting, with lower channel numbers winning. Each unit is a read from the source followed by a write of the same data to the destination, over a simple request/ready bus.

After each unit the addresses step by the unit size and the count drops by one. A pulse marks the unit that leaves half the initial count, and another marks the final unit, which also sets the channel's end flag. A misaligned address or an NMI event stops every channel and sets a global flag. Both global flags clear while the master enable is low. Burst channels keep the bus until their count runs out. Cycle-steal channels let go of it after every unit.

Top module: `dma_seq`

## Requirements
- R1: After reset, bus_req_o is low and all end flags, global flags and interrupt pulses are 0.
- R2: A channel accesses the bus only while its ch_en_i bit is 1, mst_en_i is 1, its end flag te_o is 0, ae_o is 0 and nmi_o is 0; a channel whose end flag is set makes no further accesses.
- R3: The request source is picked by rq_mode_i: 0 auto (runs with no request input), 1 ext_req_i, 2 per_req_i, 3 never. A request input that is not selected has no effect.
- R4: A unit is one read at the source address, then one write of the read data to the destination address. Unit size sz_i is 0 byte, 1 halfword, 2 word, 3 16-byte and is shown on bus_size_o. Each unit lowers the count by 1. The configuration is latched when ch_en_i rises.
- R5: Address modes src_mode_i/dst_mode_i are 0 fixed, 1 increment, 2 decrement and 3 fixed. The step is the unit size in bytes (1, 2, 4, 16).
- R6: half_irq_o pulses for one cycle, in the cycle after the unit that leaves the count equal to floor(initial/2). It pulses at most once per run and only when hie_i was set.
- R7: When the count reaches 0, te_o is set. end_irq_o pulses for one cycle in the following cycle when ie_i was set.
- R8: A granted channel whose source or destination address is not a multiple of the unit size sets ae_o and makes no access. While ae_o is set, no channel runs. ae_o clears while mst_en_i is 0.
- R9: A cycle with nmi_i high drops any bus request in that same cycle, sets nmi_o and stops all channels. nmi_o clears while mst_en_i is 0.
- R10: Clearing a channel's ch_en_i stops it at once, and its end flag stays 0.
- R11: In burst mode (burst_i=1), bus_req_o and bus_lock_o stay high from unit to unit until the count ends. In cycle-steal mode, bus_req_o is low for at least one cycle after each unit.
- R12: Among requesting channels the lowest index is served. The choice is made again before each cycle-steal unit.
- R13: While bus_req_o is high and bus_ready_i is low, bus_addr_o and bus_we_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mst_en_i | input | 1 | Master enable; low clears global flags |
| nmi_i | input | 1 | NMI event, aborts all channels |
| ch_en_i | input | N_CH | Channel enables; rising edge latches config |
| src_i | input | N_CH x AW | Source start address per channel |
| dst_i | input | N_CH x AW | Destination start address per channel |
| cnt_i | input | N_CH x CW | Unit count per channel |
| sz_i | input | N_CH x 2 | Unit size code per channel |
| src_mode_i | input | N_CH x 2 | Source address mode |
| dst_mode_i | input | N_CH x 2 | Destination address mode |
| rq_mode_i | input | N_CH x 2 | Request source select |
| burst_i | input | N_CH | 1 burst, 0 cycle steal |
| hie_i | input | N_CH | Half-count interrupt enable |
| ie_i | input | N_CH | End interrupt enable |
| ext_req_i | input | N_CH | External request per channel |
| per_req_i | input | N_CH | Peripheral request per channel |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | AW | Access address |
| bus_size_o | output | 2 | Access size code |
| bus_wdata_o | output | DW | Write data |
| bus_lock_o | output | 1 | Bus held for a burst |
| bus_ready_i | input | 1 | Access completes this cycle |
| bus_rdata_i | input | DW | Read data |
| te_o | output | N_CH | Transfer-end flags |
| ae_o | output | 1 | Address-error flag |
| nmi_o | output | 1 | NMI flag |
| half_irq_o | output | N_CH | Half-count interrupt pulses |
| end_irq_o | output | N_CH | Transfer-end interrupt pulses |

## Verification
Several rules are checked on every cycle. Each unit lowers the count by exactly one. The end flag rises only after a final unit, and half pulses occur only after a unit with the enable latched. The grant is one-hot and covers only requesting channels. Address and direction hold while the bus waits, the bus drops after each cycle-steal unit, and no request is made while the address-error flag is set. Other behaviour shows only in the bench's scenarios: the exact order and data of accesses, the priority sequence, how request sources are chosen, the one-time half pulse, aborts by NMI, enable clear and misalignment, and clearing the flags with the master enable.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} seq_st_e;

  localparam logic [1:0] RQ_AUTO = 2'd0;
  localparam logic [1:0] RQ_EXT  = 2'd1;
  localparam logic [1:0] RQ_PER  = 2'd2;

  localparam logic [1:0] AM_INC = 2'd1;
  localparam logic [1:0] AM_DEC = 2'd2;

  function automatic logic [4:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    unit_bytes = 5'd1;
      2'd1:    unit_bytes = 5'd2;
      2'd2:    unit_bytes = 5'd4;
      default: unit_bytes = 5'd16;
    endcase
  endfunction

  function automatic logic misaligned(input logic [3:0] lo, input logic [1:0] sz);
    logic [4:0] m;
    m = unit_bytes(sz) - 5'd1;
    misaligned = (lo & m[3:0]) != 4'd0;
  endfunction
endpackage

// File: rtl/dma_chan.sv
module dma_chan import dma_pkg::*; #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          glob_ok_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [1:0]    sz_i,
  input  logic [1:0]    src_mode_i,
  input  logic [1:0]    dst_mode_i,
  input  logic [1:0]    rq_mode_i,
  input  logic          burst_i,
  input  logic          hie_i,
  input  logic          ie_i,
  input  logic          ext_req_i,
  input  logic          per_req_i,
  input  logic          upd_i,
  output logic          ok_o,
  output logic          req_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [1:0]    sz_o,
  output logic          burst_o,
  output logic          last_o,
  output logic          te_o,
  output logic          half_irq_o,
  output logic          end_irq_o
);
  logic          en_q, te_q, half_seen_q, half_irq_q, end_irq_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q, init_q;
  logic [1:0]    sz_q, smode_q, dmode_q, rq_q;
  logic          burst_q, hie_q, ie_q;
  logic          load, sel;
  logic [CW-1:0] cnt_nx;
  logic [AW-1:0] ub;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m,
                                         input logic [AW-1:0] d);
    case (m)
      AM_INC:  step = a + d;
      AM_DEC:  step = a - d;
      default: step = a;
    endcase
  endfunction

  assign load   = en_i & ~en_q;
  assign cnt_nx = cnt_q - CW'(1);
  assign ub     = AW'(unit_bytes(sz_q));

  always_comb begin
    case (rq_q)
      RQ_AUTO: sel = 1'b1;
      RQ_EXT:  sel = ext_req_i;
      RQ_PER:  sel = per_req_i;
      default: sel = 1'b0;
    endcase
  end

  // enable is used live so that clearing it stops the channel in the same cycle
  assign ok_o       = en_i & en_q & glob_ok_i & ~te_q & (cnt_q != '0);
  assign req_o      = ok_o & sel;
  assign src_o      = src_q;
  assign dst_o      = dst_q;
  assign sz_o       = sz_q;
  assign burst_o    = burst_q;
  assign last_o     = cnt_q == CW'(1);
  assign te_o       = te_q;
  assign half_irq_o = half_irq_q;
  assign end_irq_o  = end_irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; te_q <= 1'b0; half_seen_q <= 1'b0;
      half_irq_q <= 1'b0; end_irq_q <= 1'b0;
      src_q <= '0; dst_q <= '0; cnt_q <= '0; init_q <= '0;
      sz_q <= '0; smode_q <= '0; dmode_q <= '0; rq_q <= '0;
      burst_q <= 1'b0; hie_q <= 1'b0; ie_q <= 1'b0;
    end else begin
      en_q       <= en_i;
      half_irq_q <= 1'b0;
      end_irq_q  <= 1'b0;
      if (load) begin
        src_q <= src_i; dst_q <= dst_i; cnt_q <= cnt_i; init_q <= cnt_i;
        sz_q <= sz_i; smode_q <= src_mode_i; dmode_q <= dst_mode_i; rq_q <= rq_mode_i;
        burst_q <= burst_i; hie_q <= hie_i; ie_q <= ie_i;
        te_q <= 1'b0; half_seen_q <= 1'b0;
      end else if (upd_i) begin
        src_q <= step(src_q, smode_q, ub);
        dst_q <= step(dst_q, dmode_q, ub);
        cnt_q <= cnt_nx;
        if (cnt_q == CW'(1)) begin
          te_q      <= 1'b1;
          end_irq_q <= ie_q;
        end
        if (!half_seen_q && cnt_nx == (init_q >> 1)) begin
          half_seen_q <= 1'b1;
          half_irq_q  <= hie_q;
        end
      end
    end
  end

  // R4
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> cnt_q == $past(cnt_q) - CW'(1));
  // R7
  te_after_unit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(te_q) |-> $past(upd_i));
  // R6
  half_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_irq_o |-> ($past(upd_i) && hie_q));
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int unsigned N_CH = 2,
  parameter int unsigned CIW  = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] req_i,
  output logic [N_CH-1:0] gnt_o,
  output logic [CIW-1:0]  idx_o,
  output logic            vld_o
);
  for (genvar i = 0; i < N_CH; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign gnt_o[i] = req_i[i];
    end else begin : g_low
      assign gnt_o[i] = req_i[i] & ~(|req_i[i-1:0]);
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (gnt_o[i]) idx_o = CIW'(i);
    end
  end

  assign vld_o = |req_i;

  // R12
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));
endmodule

// File: rtl/dma_ctl.sv
module dma_ctl import dma_pkg::*; #(
  parameter int unsigned N_CH = 2,
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned CIW  = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      gnt_vld_i,
  input  logic [CIW-1:0]            gnt_idx_i,
  input  logic [N_CH-1:0]           ok_i,
  input  logic [N_CH-1:0][AW-1:0]   src_i,
  input  logic [N_CH-1:0][AW-1:0]   dst_i,
  input  logic [N_CH-1:0][1:0]      sz_i,
  input  logic [N_CH-1:0]           burst_i,
  input  logic [N_CH-1:0]           last_i,
  input  logic                      bus_ready_i,
  input  logic [DW-1:0]             bus_rdata_i,
  output logic                      bus_req_o,
  output logic                      bus_we_o,
  output logic [AW-1:0]             bus_addr_o,
  output logic [1:0]                bus_size_o,
  output logic [DW-1:0]             bus_wdata_o,
  output logic                      bus_lock_o,
  output logic [N_CH-1:0]           upd_o,
  output logic                      ae_set_o
);
  seq_st_e        st_q;
  logic [CIW-1:0] cur_q;
  logic [DW-1:0]  data_q;
  logic           bad_addr, live, wr_done;

  assign bad_addr = misaligned(src_i[gnt_idx_i][3:0], sz_i[gnt_idx_i]) |
                    misaligned(dst_i[gnt_idx_i][3:0], sz_i[gnt_idx_i]);
  assign live     = (st_q != ST_IDLE) & ok_i[cur_q];
  assign wr_done  = (st_q == ST_WR) & ok_i[cur_q] & bus_ready_i;
  assign ae_set_o = (st_q == ST_IDLE) & gnt_vld_i & bad_addr;

  always_comb begin
    upd_o = '0;
    if (wr_done) upd_o[cur_q] = 1'b1;
  end

  assign bus_req_o   = live;
  assign bus_we_o    = st_q == ST_WR;
  assign bus_addr_o  = (st_q == ST_WR) ? dst_i[cur_q] : src_i[cur_q];
  assign bus_size_o  = sz_i[cur_q];
  assign bus_wdata_o = data_q;
  assign bus_lock_o  = live & burst_i[cur_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (gnt_vld_i && !bad_addr) begin
          cur_q <= gnt_idx_i;
          st_q  <= ST_RD;
        end
        ST_RD: if (!ok_i[cur_q]) st_q <= ST_IDLE;
               else if (bus_ready_i) begin
                 data_q <= bus_rdata_i;
                 st_q   <= ST_WR;
               end
        ST_WR: if (!ok_i[cur_q]) st_q <= ST_IDLE;
               else if (bus_ready_i)
                 st_q <= (burst_i[cur_q] && !last_i[cur_q]) ? ST_RD : ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R13
  hold_while_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i) |=> (!bus_req_o || ($stable(bus_addr_o) && $stable(bus_we_o))));
  // R11
  steal_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_done && !burst_i[cur_q]) |=> !bus_req_o);
  // R8
  no_access_on_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ae_set_o |=> !bus_req_o);
endmodule

// File: rtl/dma_seq.sv
module dma_seq import dma_pkg::*; #(
  parameter int unsigned N_CH = 2,
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned CW   = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mst_en_i,
  input  logic                    nmi_i,
  input  logic [N_CH-1:0]         ch_en_i,
  input  logic [N_CH-1:0][AW-1:0] src_i,
  input  logic [N_CH-1:0][AW-1:0] dst_i,
  input  logic [N_CH-1:0][CW-1:0] cnt_i,
  input  logic [N_CH-1:0][1:0]    sz_i,
  input  logic [N_CH-1:0][1:0]    src_mode_i,
  input  logic [N_CH-1:0][1:0]    dst_mode_i,
  input  logic [N_CH-1:0][1:0]    rq_mode_i,
  input  logic [N_CH-1:0]         burst_i,
  input  logic [N_CH-1:0]         hie_i,
  input  logic [N_CH-1:0]         ie_i,
  input  logic [N_CH-1:0]         ext_req_i,
  input  logic [N_CH-1:0]         per_req_i,
  output logic                    bus_req_o,
  output logic                    bus_we_o,
  output logic [AW-1:0]           bus_addr_o,
  output logic [1:0]              bus_size_o,
  output logic [DW-1:0]           bus_wdata_o,
  output logic                    bus_lock_o,
  input  logic                    bus_ready_i,
  input  logic [DW-1:0]           bus_rdata_i,
  output logic [N_CH-1:0]         te_o,
  output logic                    ae_o,
  output logic                    nmi_o,
  output logic [N_CH-1:0]         half_irq_o,
  output logic [N_CH-1:0]         end_irq_o
);
  localparam int unsigned CIW = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic                    ae_q, nmi_q, glob_ok, ae_set, gvld;
  logic [CIW-1:0]          gidx;
  logic [N_CH-1:0]         ok, req, burst, last, upd, gnt;
  logic [N_CH-1:0][AW-1:0] src, dst;
  logic [N_CH-1:0][1:0]    sz;

  // nmi_i gates the same cycle so no access completes after the event
  assign glob_ok = mst_en_i & ~ae_q & ~nmi_q & ~nmi_i;
  assign ae_o    = ae_q;
  assign nmi_o   = nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q  <= 1'b0;
      nmi_q <= 1'b0;
    end else if (!mst_en_i) begin
      ae_q  <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      ae_q  <= ae_q | ae_set;
      nmi_q <= nmi_q | nmi_i;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dma_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk_i, .rst_ni,
      .en_i(ch_en_i[c]), .glob_ok_i(glob_ok),
      .src_i(src_i[c]), .dst_i(dst_i[c]), .cnt_i(cnt_i[c]), .sz_i(sz_i[c]),
      .src_mode_i(src_mode_i[c]), .dst_mode_i(dst_mode_i[c]), .rq_mode_i(rq_mode_i[c]),
      .burst_i(burst_i[c]), .hie_i(hie_i[c]), .ie_i(ie_i[c]),
      .ext_req_i(ext_req_i[c]), .per_req_i(per_req_i[c]), .upd_i(upd[c]),
      .ok_o(ok[c]), .req_o(req[c]), .src_o(src[c]), .dst_o(dst[c]), .sz_o(sz[c]),
      .burst_o(burst[c]), .last_o(last[c]), .te_o(te_o[c]),
      .half_irq_o(half_irq_o[c]), .end_irq_o(end_irq_o[c])
    );
  end

  dma_arb #(.N_CH(N_CH), .CIW(CIW)) u_arb (
    .clk_i, .rst_ni, .req_i(req), .gnt_o(gnt), .idx_o(gidx), .vld_o(gvld)
  );

  dma_ctl #(.N_CH(N_CH), .AW(AW), .DW(DW), .CIW(CIW)) u_ctl (
    .clk_i, .rst_ni, .gnt_vld_i(gvld), .gnt_idx_i(gidx), .ok_i(ok),
    .src_i(src), .dst_i(dst), .sz_i(sz), .burst_i(burst), .last_i(last),
    .bus_ready_i, .bus_rdata_i, .bus_req_o, .bus_we_o, .bus_addr_o, .bus_size_o,
    .bus_wdata_o, .bus_lock_o, .upd_o(upd), .ae_set_o(ae_set)
  );

  // R8
  no_req_on_ae_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ae_o |-> !bus_req_o);
  // R9
  nmi_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i || nmi_o) |-> !bus_req_o);
  // R2
  te_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd & te_o) == '0);
endmodule

// File: tb/dma_seq_bench.sv
module dma_seq_bench;
  localparam int N = 2;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam logic [31:0] KEY = 32'hA5A5_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni, mst_en, nmi;
  logic [N-1:0] ch_en, burst, hie, ie, ext_req, per_req;
  logic [N-1:0][AW-1:0] src, dst;
  logic [N-1:0][CW-1:0] cnt;
  logic [N-1:0][1:0] sz, smode, dmode, rqm;
  logic bus_req, bus_we, bus_lock, bus_ready;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_size;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [N-1:0] te, half_irq, end_irq;
  logic ae, nmi_f;

  assign bus_rdata = bus_addr ^ KEY;

  dma_seq #(.N_CH(N), .AW(AW), .DW(DW), .CW(CW)) u_dma_seq (
    .clk_i(clk), .rst_ni, .mst_en_i(mst_en), .nmi_i(nmi), .ch_en_i(ch_en),
    .src_i(src), .dst_i(dst), .cnt_i(cnt), .sz_i(sz), .src_mode_i(smode),
    .dst_mode_i(dmode), .rq_mode_i(rqm), .burst_i(burst), .hie_i(hie), .ie_i(ie),
    .ext_req_i(ext_req), .per_req_i(per_req), .bus_req_o(bus_req), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_size_o(bus_size), .bus_wdata_o(bus_wdata),
    .bus_lock_o(bus_lock), .bus_ready_i(bus_ready), .bus_rdata_i(bus_rdata),
    .te_o(te), .ae_o(ae), .nmi_o(nmi_f), .half_irq_o(half_irq), .end_irq_o(end_irq)
  );

  typedef struct packed {logic [31:0] a; logic we; logic [31:0] d; logic [1:0] s;} acc_t;
  acc_t exp_q[$];

  int total = 0, bad = 0, hs_cnt = 0;
  int half_cnt[N], end_cnt[N];
  bit exp_burst = 0, gap_chk = 0, alt_rdy = 0, fin = 0;
  string tag = "R4";

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic push_unit(input logic [31:0] s, input logic [31:0] d, input logic [1:0] z);
    exp_q.push_back('{a: s, we: 1'b0, d: 32'h0, s: z});
    exp_q.push_back('{a: d, we: 1'b1, d: s ^ KEY, s: z});
  endtask

  task automatic cfg(input int c, input logic [31:0] s, input logic [31:0] d, input logic [15:0] n,
                     input logic [1:0] z, input logic [1:0] sm, input logic [1:0] dm,
                     input logic [1:0] rm, input bit b, input bit h, input bit e);
    src[c] = s; dst[c] = d; cnt[c] = n; sz[c] = z; smode[c] = sm; dmode[c] = dm;
    rqm[c] = rm; burst[c] = b; hie[c] = h; ie[c] = e;
  endtask

  task automatic clr_irq();
    for (int c = 0; c < N; c++) begin half_cnt[c] = 0; end_cnt[c] = 0; end
  endtask

  task automatic wait_empty(input int lim);
    for (int i = 0; i < lim && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " all accesses seen"}, exp_q.size(), 0);
  endtask

  task automatic idle_check(input int n, input string r);
    int snap;
    snap = hs_cnt;
    repeat (n) @(negedge clk);
    chk(hs_cnt == snap, r, hs_cnt - snap, 0);
  endtask

  task automatic clear_globals();
    @(negedge clk); mst_en = 1'b0;
    @(negedge clk); mst_en = 1'b1;
  endtask

  // cycle-based reference: expected access queue, gap/hold rules, pulse counters
  initial begin : mon
    bit prev_wr, prev_wait, hs;
    logic [AW-1:0] prev_addr;
    acc_t e;
    prev_wr = 0; prev_wait = 0; prev_addr = '0;
    bus_ready = 1'b1;
    forever begin
      @(negedge clk);
      bus_ready = alt_rdy ? ~bus_ready : 1'b1;
      #4;
      if (rst_ni) begin
        hs = bus_req && bus_ready;
        if (prev_wr && gap_chk) begin
          if (!exp_burst) chk(!bus_req, "R11 cycle-steal gap", bus_req, 0);
          else if (exp_q.size() > 0)
            chk(bus_req && bus_lock, "R11 burst hold", {bus_req, bus_lock}, 2'b11);
        end
        if (prev_wait && bus_req) chk(bus_addr == prev_addr, "R13 held address", bus_addr, prev_addr);
        if (hs) begin
          hs_cnt++;
          if (exp_q.size() == 0) chk(0, {tag, " unexpected access"}, bus_addr, 0);
          else begin
            e = exp_q.pop_front();
            chk(bus_addr == e.a && bus_we == e.we && bus_size == e.s, {tag, " access"},
                {bus_size, bus_we, bus_addr}, {e.s, e.we, e.a});
            if (e.we) chk(bus_wdata == e.d, "R4 write data", bus_wdata, e.d);
          end
        end
        prev_wr   = hs && bus_we;
        prev_wait = bus_req && !bus_ready;
        prev_addr = bus_addr;
        for (int c = 0; c < N; c++) begin
          half_cnt[c] += int'(half_irq[c]);
          end_cnt[c]  += int'(end_irq[c]);
        end
      end
    end
  end

  initial begin : wdog
    repeat (50000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int snap;
    rst_ni = 1'b0; mst_en = 1'b0; nmi = 1'b0; ch_en = '0; ext_req = '0; per_req = '0;
    src = '0; dst = '0; cnt = '0; sz = '0; smode = '0; dmode = '0; rqm = '0;
    burst = '0; hie = '0; ie = '0;
    clr_irq();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(!bus_req, "R1 bus_req after reset", bus_req, 0);
    chk(te == '0 && !ae && !nmi_f, "R1 flags after reset", {te, ae, nmi_f}, 0);
    chk(half_irq == '0 && end_irq == '0, "R1 irqs after reset", {half_irq, end_irq}, 0);
    mst_en = 1'b1;

    // ch0 auto, word, inc/inc, cycle steal, slow ready
    tag = "R5"; alt_rdy = 1; gap_chk = 1; exp_burst = 0; clr_irq();
    cfg(0, 32'h100, 32'h200, 16'd4, 2'd2, 2'd1, 2'd1, 2'd0, 0, 1, 1);
    for (int i = 0; i < 4; i++) push_unit(32'h100 + 4*i, 32'h200 + 4*i, 2'd2);
    @(negedge clk); ch_en[0] = 1'b1;
    wait_empty(200);
    chk(te[0], "R7 end flag set", te[0], 1);
    chk(half_cnt[0] == 1, "R6 half pulse count", half_cnt[0], 1);
    chk(end_cnt[0] == 1, "R7 end pulse count", end_cnt[0], 1);
    idle_check(10, "R2 no access after end flag");
    @(negedge clk); ch_en[0] = 1'b0; alt_rdy = 0;

    // ch1 external request, burst, halfword, src decrement, dst fixed
    tag = "R3"; exp_burst = 1; clr_irq();
    cfg(1, 32'h300, 32'h400, 16'd3, 2'd1, 2'd2, 2'd0, 2'd1, 1, 1, 1);
    @(negedge clk); ch_en[1] = 1'b1; per_req[1] = 1'b1;
    idle_check(10, "R3 unselected source ignored");
    per_req[1] = 1'b0;
    push_unit(32'h300, 32'h400, 2'd1);
    push_unit(32'h2FE, 32'h400, 2'd1);
    push_unit(32'h2FC, 32'h400, 2'd1);
    @(negedge clk); ext_req[1] = 1'b1;
    @(negedge clk); ext_req[1] = 1'b0;
    tag = "R11"; wait_empty(100);
    chk(half_cnt[1] == 1 && end_cnt[1] == 1, "R6 burst pulses", {half_cnt[1], end_cnt[1]}, {32'd1, 32'd1});
    @(negedge clk); ch_en[1] = 1'b0;

    // priority: both auto, cycle steal, start together
    tag = "R12"; exp_burst = 0; clr_irq();
    cfg(0, 32'h500, 32'h600, 16'd2, 2'd2, 2'd1, 2'd1, 2'd0, 0, 0, 0);
    cfg(1, 32'h700, 32'h800, 16'd2, 2'd2, 2'd1, 2'd1, 2'd0, 0, 0, 0);
    push_unit(32'h500, 32'h600, 2'd2);
    push_unit(32'h504, 32'h604, 2'd2);
    push_unit(32'h700, 32'h800, 2'd2);
    push_unit(32'h704, 32'h804, 2'd2);
    @(negedge clk); ch_en = 2'b11;
    wait_empty(100);
    chk(te == 2'b11, "R12 both ended", te, 2'b11);
    chk(half_cnt[0] == 0 && end_cnt[0] == 0, "R6 pulses masked", {half_cnt[0], end_cnt[0]}, 0);
    @(negedge clk); ch_en = 2'b00;

    // misaligned source
    tag = "R8";
    cfg(0, 32'h902, 32'hA00, 16'd2, 2'd2, 2'd1, 2'd1, 2'd0, 0, 0, 0);
    @(negedge clk); ch_en[0] = 1'b1;
    idle_check(10, "R8 no access on misaligned");
    chk(ae && !te[0], "R8 error flag", {ae, te[0]}, 2'b10);
    @(negedge clk); ch_en[0] = 1'b0;
    clear_globals();
    @(negedge clk);
    chk(!ae, "R8 flag cleared by master enable", ae, 0);

    // NMI during a burst
    tag = "R9"; exp_burst = 1; gap_chk = 0;
    cfg(0, 32'hA00, 32'hB00, 16'd8, 2'd2, 2'd1, 2'd1, 2'd0, 1, 0, 0);
    for (int i = 0; i < 8; i++) push_unit(32'hA00 + 4*i, 32'hB00 + 4*i, 2'd2);
    snap = hs_cnt;
    @(negedge clk); ch_en[0] = 1'b1;
    while (hs_cnt < snap + 3) @(negedge clk);
    nmi = 1'b1;
    idle_check(1, "R9 same-cycle abort");
    nmi = 1'b0;
    idle_check(20, "R9 stays stopped");
    chk(nmi_f && !te[0], "R9 nmi flag", {nmi_f, te[0]}, 2'b10);
    exp_q.delete();
    @(negedge clk); ch_en[0] = 1'b0;
    clear_globals();
    @(negedge clk);
    chk(!nmi_f, "R9 flag cleared by master enable", nmi_f, 0);

    // enable clear mid-run, byte units
    tag = "R10"; exp_burst = 0; clr_irq();
    cfg(1, 32'hC00, 32'hD00, 16'd6, 2'd0, 2'd1, 2'd1, 2'd0, 0, 1, 1);
    for (int i = 0; i < 6; i++) push_unit(32'hC00 + i, 32'hD00 + i, 2'd0);
    snap = hs_cnt;
    @(negedge clk); ch_en[1] = 1'b1;
    while (hs_cnt < snap + 4) @(negedge clk);
    ch_en[1] = 1'b0;
    idle_check(20, "R10 stopped by enable clear");
    chk(!te[1] && end_cnt[1] == 0, "R10 no end on stop", {te[1], end_cnt[1]}, 0);
    exp_q.delete();

    // peripheral request, 16-byte units
    tag = "R3"; gap_chk = 1; clr_irq();
    cfg(0, 32'hE00, 32'hF00, 16'd2, 2'd3, 2'd1, 2'd1, 2'd2, 0, 1, 1);
    @(negedge clk); ch_en[0] = 1'b1; ext_req[0] = 1'b1;
    idle_check(10, "R3 external pin ignored in peripheral mode");
    ext_req[0] = 1'b0;
    push_unit(32'hE00, 32'hF00, 2'd3);
    push_unit(32'hE10, 32'hF10, 2'd3);
    per_req[0] = 1'b1;
    tag = "R5"; wait_empty(100);
    per_req[0] = 1'b0;
    chk(half_cnt[0] == 1 && end_cnt[0] == 1 && te[0], "R7 peripheral run end",
        {half_cnt[0], end_cnt[0]}, {32'd1, 32'd1});
    @(negedge clk); ch_en[0] = 1'b0;

    // single unit, fixed odd source, end interrupt masked
    tag = "R4"; clr_irq();
    cfg(1, 32'h1001, 32'h2003, 16'd1, 2'd0, 2'd0, 2'd1, 2'd0, 0, 1, 0);
    push_unit(32'h1001, 32'h2003, 2'd0);
    @(negedge clk); ch_en[1] = 1'b1;
    wait_empty(50);
    chk(te[1] && end_cnt[1] == 0, "R7 end flag without pulse", {te[1], end_cnt[1]}, 2'b10);
    chk(half_cnt[1] == 1, "R6 half pulse at count one", half_cnt[1], 1);
    @(negedge clk); ch_en[1] = 1'b0;

    repeat (3) @(negedge clk);
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule